// File: doc/BRIEF.md
# Trace Line Fill Packer

This block sits between a one-instruction-per-cycle decoder and a micro-operation buffer that feeds allocation. It only does work after a trace miss. During refill the decoder hands over up to four decoded micro-operations per cycle. They arrive in predicted program order, so the micro-ops that follow a predicted-taken branch belong to its target. The packer collects them into lines of six slots and never breaks a line at a taken branch. Each finished line goes into a small register-array line store, tagged with the address of the line's first micro-op.

On the fetch side a requester presents a trace start address. The store is searched once every two core cycles. A matching line is moved whole into the micro-op buffer, and the buffer hands up to three micro-ops per cycle to the next stage while the consumer is ready. A trace-end (flush) pulse closes a partly filled line. That line is stored with per-slot valid bits, so a fetch of it delivers only the filled slots.

Top module: `tlp_trace_fill`

## Requirements
- R1: Micro-ops are collected into six-slot lines. A line is written to the store in the cycle its sixth slot is filled, and a later fetch returns its micro-ops in the order they were accepted.
- R2: Each cycle `in_cnt` micro-ops are accepted from lanes 0 upward, where lane i occupies bits [i*16 +: 16] of `in_uop` and `in_addr`. A value above 4 is taken as 4. Micro-ops that do not fit into the current line start the next one.
- R3: A taken-branch marker (`in_taken` bit i for lane i) neither closes nor splits a line. The marker travels with its micro-op and appears on the matching `out_taken` lane.
- R4: When `in_flush` is high, the micro-ops held after that cycle's input are written as a partial line, and the packer is left empty. If that cycle also completes a full line, both lines are written in the same cycle, the full one first. A fetch of a partial line delivers only its filled slots.
- R5: A line's tag is the address of its first micro-op. A fetch whose address matches no stored tag raises `fetch_miss` and moves nothing.
- R6: Fetch requests are served only in even cycles, counting the first clock edge after reset release as cycle 0. A request in an odd cycle gets no response. `fetch_hit`, `fetch_miss` and `fetch_stall` are combinational in the serving cycle, and at most one of them is high.
- R7: While `out_ready` is high, min(3, occupancy) micro-ops leave the buffer each cycle, oldest first, on `out_valid` lanes 0 upward (lane o is bits [o*16 +: 16] of `out_uop`). While `out_ready` is low, nothing leaves.
- R8: A hit is accepted only if the buffer, of depth 12, has at least six free entries, measured before that cycle's drain. Otherwise `fetch_stall` is raised, the buffer contents are unchanged apart from the drain, and a later retry can succeed.
- R9: The store keeps the four most recently written lines. A new line replaces the oldest one.
- R10: After reset the store and buffer are empty, no output is asserted, and every fetch misses.
- R11: A lookup in the same cycle as a store write sees the store as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_cnt | input | 3 | Number of micro-ops offered this cycle (0 to 4) |
| in_uop | input | 64 | Four micro-op lanes of 16 bits |
| in_taken | input | 4 | Taken-branch marker per lane |
| in_addr | input | 64 | Four 16-bit micro-op addresses |
| in_flush | input | 1 | Trace end: close the partial line |
| fetch_req | input | 1 | Fetch request |
| fetch_addr | input | 16 | Trace start address to look up |
| out_ready | input | 1 | Next stage accepts micro-ops this cycle |
| fetch_hit | output | 1 | Line found and moved to the buffer |
| fetch_miss | output | 1 | No line with a matching tag |
| fetch_stall | output | 1 | Line found but the buffer lacks room |
| out_valid | output | 3 | Per-lane valid of the drained micro-ops |
| out_uop | output | 48 | Three drained micro-op lanes |
| out_taken | output | 3 | Taken markers of the drained lanes |

## Verification
The stall case is the hardest to reach. A hit has to arrive while the buffer holds more than six entries, and that only happens after the consumer has been held off for several fetch windows. The stimulus drops `out_ready`, hits stored lines in successive even cycles until a third hit stalls, and then retries while draining. It also steers a line-completing push, and a flush that spills into a second line, onto an even cycle with a fetch of the same tag. This shows that lookups see the store as it was before the write. A long pseudo-random phase mixes all of these situations against the queue-based model.

// File: rtl/tlp_pkg.sv
package tlp_pkg;

  // Modular increment for circular indices (step is always non-negative).
  function automatic int wrap_add(input int base, input int step, input int modulo);
    return (base + step) % modulo;
  endfunction

  // Number of entries leaving a buffer this cycle.
  function automatic int drain_count(input int held, input int lanes, input logic ready);
    if (!ready) return 0;
    return (held < lanes) ? held : lanes;
  endfunction

  // True when a whole line fits into the buffer at its current occupancy.
  function automatic logic has_line_room(input int held, input int depth, input int slots);
    return (depth - held) >= slots;
  endfunction

  // Clamp an offered count to the lane count.
  function automatic int clamp_count(input int req, input int lim);
    return (req > lim) ? lim : req;
  endfunction

endpackage

// File: rtl/tlp_packer.sv
module tlp_packer import tlp_pkg::*; #(
  parameter int SLOTS  = 6,
  parameter int IN_W   = 4,
  parameter int UOP_W  = 16,
  parameter int ADDR_W = 16,
  localparam int CNT_W = $clog2(IN_W + 1),
  localparam int HC_W  = $clog2(SLOTS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CNT_W-1:0]         in_cnt,
  input  logic [IN_W*UOP_W-1:0]    in_uop,
  input  logic [IN_W-1:0]          in_taken,
  input  logic [IN_W*ADDR_W-1:0]   in_addr,
  input  logic                     in_flush,
  output logic                     wa_en,
  output logic [ADDR_W-1:0]        wa_tag,
  output logic [SLOTS*UOP_W-1:0]   wa_uop,
  output logic [SLOTS-1:0]         wa_tk,
  output logic [SLOTS-1:0]         wa_vm,
  output logic                     wb_en,
  output logic [ADDR_W-1:0]        wb_tag,
  output logic [SLOTS*UOP_W-1:0]   wb_uop,
  output logic [SLOTS-1:0]         wb_tk,
  output logic [SLOTS-1:0]         wb_vm,
  output logic [HC_W-1:0]          held_cnt
);

  localparam int TOT = SLOTS + IN_W;
  localparam int LSW = (IN_W > 1) ? $clog2(IN_W) : 1;

  logic [UOP_W-1:0]  hold_uop  [SLOTS];
  logic [ADDR_W-1:0] hold_addr [SLOTS];
  logic [SLOTS-1:0]  hold_tk;

  logic [UOP_W-1:0]  lane_uop  [IN_W];
  logic [ADDR_W-1:0] lane_addr [IN_W];

  logic [UOP_W-1:0]  cat_uop  [TOT];
  logic [ADDR_W-1:0] cat_addr [TOT];
  logic [TOT-1:0]    cat_tk;

  logic [UOP_W-1:0]  nxt_uop  [SLOTS];
  logic [ADDR_W-1:0] nxt_addr [SLOTS];
  logic [SLOTS-1:0]  nxt_tk;

  int   eff_in, total, rest, keep_n;
  logic full;

  always_comb begin
    eff_in = clamp_count(int'(in_cnt), IN_W);
    total  = int'(held_cnt) + eff_in;
    full   = total >= SLOTS;
    rest   = full ? total - SLOTS : 0;
    keep_n = in_flush ? 0 : (full ? rest : total);
  end

  for (genvar i = 0; i < IN_W; i++) begin : g_lane
    assign lane_uop[i]  = in_uop[i*UOP_W +: UOP_W];
    assign lane_addr[i] = in_addr[i*ADDR_W +: ADDR_W];
  end

  // Concatenate held slots and this cycle's lanes in program order.
  for (genvar k = 0; k < TOT; k++) begin : g_cat
    int                j;
    logic              lane_ok;
    logic [UOP_W-1:0]  lu;
    logic [ADDR_W-1:0] la;
    logic              lt;
    always_comb begin
      j       = k - int'(held_cnt);
      lane_ok = (j >= 0) && (j < eff_in);
      lu      = lane_ok ? lane_uop[j[LSW-1:0]]  : '0;
      la      = lane_ok ? lane_addr[j[LSW-1:0]] : '0;
      lt      = lane_ok ? in_taken[j[LSW-1:0]]  : 1'b0;
    end
    if (k < SLOTS) begin : g_h
      logic from_hold;
      assign from_hold   = k < int'(held_cnt);
      assign cat_uop[k]  = from_hold ? hold_uop[k]  : lu;
      assign cat_addr[k] = from_hold ? hold_addr[k] : la;
      assign cat_tk[k]   = from_hold ? hold_tk[k]   : lt;
    end else begin : g_l
      assign cat_uop[k]  = lu;
      assign cat_addr[k] = la;
      assign cat_tk[k]   = lt;
    end
  end

  // Line A: the first six concatenated slots (full or flushed partial line).
  // Line B: the spill beyond six, written only when a flush closes it.
  assign wa_en  = full || (in_flush && total > 0);
  assign wa_tag = cat_addr[0];
  assign wb_en  = in_flush && rest > 0;
  assign wb_tag = cat_addr[SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign wa_uop[s*UOP_W +: UOP_W] = cat_uop[s];
    assign wa_tk[s] = cat_tk[s];
    assign wa_vm[s] = s < total;
    if (s < IN_W) begin : g_spill
      assign wb_uop[s*UOP_W +: UOP_W] = cat_uop[SLOTS+s];
      assign wb_tk[s]    = cat_tk[SLOTS+s];
      assign wb_vm[s]    = s < rest;
      assign nxt_uop[s]  = full ? cat_uop[SLOTS+s]  : cat_uop[s];
      assign nxt_addr[s] = full ? cat_addr[SLOTS+s] : cat_addr[s];
      assign nxt_tk[s]   = full ? cat_tk[SLOTS+s]   : cat_tk[s];
    end else begin : g_nospill
      assign wb_uop[s*UOP_W +: UOP_W] = '0;
      assign wb_tk[s]    = 1'b0;
      assign wb_vm[s]    = 1'b0;
      assign nxt_uop[s]  = cat_uop[s];
      assign nxt_addr[s] = cat_addr[s];
      assign nxt_tk[s]   = cat_tk[s];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) held_cnt <= '0;
    else        held_cnt <= HC_W'(keep_n);
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < SLOTS; s++) begin
      hold_uop[s]  <= nxt_uop[s];
      hold_addr[s] <= nxt_addr[s];
    end
    hold_tk <= nxt_tk;
  end

endmodule

// File: rtl/tlp_line_store.sv
module tlp_line_store import tlp_pkg::*; #(
  parameter int SLOTS  = 6,
  parameter int LINES  = 4,
  parameter int UOP_W  = 16,
  parameter int ADDR_W = 16,
  localparam int LW = SLOTS * UOP_W,
  localparam int PW = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int NW = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wa_en,
  input  logic [ADDR_W-1:0] wa_tag,
  input  logic [LW-1:0]     wa_uop,
  input  logic [SLOTS-1:0]  wa_tk,
  input  logic [SLOTS-1:0]  wa_vm,
  input  logic              wb_en,
  input  logic [ADDR_W-1:0] wb_tag,
  input  logic [LW-1:0]     wb_uop,
  input  logic [SLOTS-1:0]  wb_tk,
  input  logic [SLOTS-1:0]  wb_vm,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              look_hit,
  output logic [LW-1:0]     look_uop,
  output logic [SLOTS-1:0]  look_tk,
  output logic [NW-1:0]     look_n
);

  logic [LINES-1:0]  ent_v;
  logic [ADDR_W-1:0] ent_tag [LINES];
  logic [LW-1:0]     ent_uop [LINES];
  logic [SLOTS-1:0]  ent_tk  [LINES];
  logic [SLOTS-1:0]  ent_vm  [LINES];
  logic [PW-1:0]     wptr, slot_a, slot_b, hit_idx;

  // Round-robin replacement: line A at the pointer, line B right after it.
  assign slot_a = wptr;
  assign slot_b = PW'(wrap_add(int'(wptr), 1, LINES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v <= '0;
      wptr  <= '0;
    end else begin
      if (wa_en) ent_v[slot_a] <= 1'b1;
      if (wb_en) ent_v[slot_b] <= 1'b1;
      wptr <= PW'(wrap_add(int'(wptr), int'(wa_en) + int'(wb_en), LINES));
    end
  end

  always_ff @(posedge clk) begin
    if (wa_en) begin
      ent_tag[slot_a] <= wa_tag;
      ent_uop[slot_a] <= wa_uop;
      ent_tk[slot_a]  <= wa_tk;
      ent_vm[slot_a]  <= wa_vm;
    end
    if (wb_en) begin
      ent_tag[slot_b] <= wb_tag;
      ent_uop[slot_b] <= wb_uop;
      ent_tk[slot_b]  <= wb_tk;
      ent_vm[slot_b]  <= wb_vm;
    end
  end

  // Tag search over the pre-write contents; lowest index wins.
  always_comb begin
    look_hit = 1'b0;
    hit_idx  = '0;
    for (int e = LINES - 1; e >= 0; e--) begin
      if (ent_v[e] && ent_tag[e] == look_addr) begin
        look_hit = 1'b1;
        hit_idx  = PW'(e);
      end
    end
  end

  assign look_uop = ent_uop[hit_idx];
  assign look_tk  = ent_tk[hit_idx];
  assign look_n   = NW'($countones(ent_vm[hit_idx]));

endmodule

// File: rtl/tlp_uop_buf.sv
module tlp_uop_buf import tlp_pkg::*; #(
  parameter int SLOTS = 6,
  parameter int OUT_W = 3,
  parameter int DEPTH = 12,
  parameter int UOP_W = 16,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int NW = $clog2(SLOTS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push_en,
  input  logic [NW-1:0]          push_n,
  input  logic [SLOTS*UOP_W-1:0] push_uop,
  input  logic [SLOTS-1:0]       push_tk,
  input  logic                   pop_ready,
  output logic [OUT_W-1:0]       out_valid,
  output logic [OUT_W*UOP_W-1:0] out_uop,
  output logic [OUT_W-1:0]       out_tk,
  output logic [CW-1:0]          fill_cnt
);

  logic [UOP_W-1:0] mem_uop [DEPTH];
  logic [DEPTH-1:0] mem_tk;
  logic [IW-1:0]    head, tail;
  int               take, added;

  assign take  = drain_count(int'(fill_cnt), OUT_W, pop_ready);
  assign added = push_en ? int'(push_n) : 0;

  for (genvar o = 0; o < OUT_W; o++) begin : g_out
    logic [IW-1:0] idx;
    assign idx          = IW'(wrap_add(int'(head), o, DEPTH));
    assign out_valid[o] = o < take;
    assign out_uop[o*UOP_W +: UOP_W] = out_valid[o] ? mem_uop[idx] : '0;
    assign out_tk[o]    = out_valid[o] ? mem_tk[idx] : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head     <= '0;
      tail     <= '0;
      fill_cnt <= '0;
    end else begin
      head     <= IW'(wrap_add(int'(head), take, DEPTH));
      tail     <= IW'(wrap_add(int'(tail), added, DEPTH));
      fill_cnt <= CW'(int'(fill_cnt) - take + added);
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < SLOTS; s++) begin
      if (s < added) begin
        mem_uop[IW'(wrap_add(int'(tail), s, DEPTH))] <= push_uop[s*UOP_W +: UOP_W];
        mem_tk[IW'(wrap_add(int'(tail), s, DEPTH))]  <= push_tk[s];
      end
    end
  end

endmodule

// File: rtl/tlp_trace_fill.sv
module tlp_trace_fill import tlp_pkg::*; #(
  parameter int SLOTS     = 6,
  parameter int IN_W      = 4,
  parameter int OUT_W     = 3,
  parameter int LINES     = 4,
  parameter int BUF_DEPTH = 12,
  parameter int UOP_W     = 16,
  parameter int ADDR_W    = 16,
  localparam int CNT_W    = $clog2(IN_W + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CNT_W-1:0]       in_cnt,
  input  logic [IN_W*UOP_W-1:0]  in_uop,
  input  logic [IN_W-1:0]        in_taken,
  input  logic [IN_W*ADDR_W-1:0] in_addr,
  input  logic                   in_flush,
  input  logic                   fetch_req,
  input  logic [ADDR_W-1:0]      fetch_addr,
  input  logic                   out_ready,
  output logic                   fetch_hit,
  output logic                   fetch_miss,
  output logic                   fetch_stall,
  output logic [OUT_W-1:0]       out_valid,
  output logic [OUT_W*UOP_W-1:0] out_uop,
  output logic [OUT_W-1:0]       out_taken
);

  localparam int HC_W = $clog2(SLOTS + 1);
  localparam int NW   = $clog2(SLOTS + 1);
  localparam int BCW  = $clog2(BUF_DEPTH + 1);
  localparam int LW   = SLOTS * UOP_W;

  // Named internal events, also watched by the checker.
  logic              wa_en, wb_en;
  logic [ADDR_W-1:0] wa_tag, wb_tag;
  logic [LW-1:0]     wa_uop, wb_uop, look_uop;
  logic [SLOTS-1:0]  wa_tk, wa_vm, wb_tk, wb_vm, look_tk;
  logic [HC_W-1:0]   held_cnt;
  logic              look_hit;
  logic [NW-1:0]     look_n;
  logic [BCW-1:0]    buf_cnt;
  logic              phase, fetch_go, line_room;

  tlp_packer #(.SLOTS(SLOTS), .IN_W(IN_W), .UOP_W(UOP_W), .ADDR_W(ADDR_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .in_cnt(in_cnt), .in_uop(in_uop), .in_taken(in_taken),
    .in_addr(in_addr), .in_flush(in_flush),
    .wa_en(wa_en), .wa_tag(wa_tag), .wa_uop(wa_uop), .wa_tk(wa_tk), .wa_vm(wa_vm),
    .wb_en(wb_en), .wb_tag(wb_tag), .wb_uop(wb_uop), .wb_tk(wb_tk), .wb_vm(wb_vm),
    .held_cnt(held_cnt)
  );

  tlp_line_store #(.SLOTS(SLOTS), .LINES(LINES), .UOP_W(UOP_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wa_en(wa_en), .wa_tag(wa_tag), .wa_uop(wa_uop), .wa_tk(wa_tk), .wa_vm(wa_vm),
    .wb_en(wb_en), .wb_tag(wb_tag), .wb_uop(wb_uop), .wb_tk(wb_tk), .wb_vm(wb_vm),
    .look_addr(fetch_addr), .look_hit(look_hit), .look_uop(look_uop),
    .look_tk(look_tk), .look_n(look_n)
  );

  // Half-rate fetch window: open when phase is low.
  always_ff @(posedge clk) begin
    if (!rst_n) phase <= 1'b0;
    else        phase <= ~phase;
  end

  assign fetch_go    = fetch_req && !phase;
  assign line_room   = has_line_room(int'(buf_cnt), BUF_DEPTH, SLOTS);
  assign fetch_hit   = fetch_go && look_hit && line_room;
  assign fetch_stall = fetch_go && look_hit && !line_room;
  assign fetch_miss  = fetch_go && !look_hit;

  tlp_uop_buf #(.SLOTS(SLOTS), .OUT_W(OUT_W), .DEPTH(BUF_DEPTH), .UOP_W(UOP_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .push_en(fetch_hit), .push_n(look_n), .push_uop(look_uop),
    .push_tk(look_tk), .pop_ready(out_ready), .out_valid(out_valid), .out_uop(out_uop),
    .out_tk(out_taken), .fill_cnt(buf_cnt)
  );

endmodule

// File: rtl/tlp_trace_fill_chk.sv
module tlp_trace_fill_chk #(
  parameter int SLOTS = 6,
  parameter int DEPTH = 12,
  parameter int OUT_W = 3,
  parameter int BCW   = 4,
  parameter int HC_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fetch_hit,
  input logic             fetch_miss,
  input logic             fetch_stall,
  input logic [OUT_W-1:0] out_valid,
  input logic [BCW-1:0]   buf_cnt,
  input logic [HC_W-1:0]  held_cnt,
  input logic             wa_en,
  input logic             wb_en,
  input logic             in_flush
);

  logic served;
  assign served = fetch_hit || fetch_miss || fetch_stall;

  p_one_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fetch_hit, fetch_miss, fetch_stall}));

  p_half_rate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    served |=> !served);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(buf_cnt) <= DEPTH);

  p_stall_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall |-> int'(buf_cnt) > DEPTH - SLOTS);

  p_stall_no_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall |=> buf_cnt <= $past(buf_cnt));

  p_drain_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_valid) <= int'(buf_cnt));

  p_drain_packed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_valid + OUT_W'(1)) & out_valid) == '0);

  p_spill_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> wa_en);

  p_flush_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_flush |=> held_cnt == '0);

  p_hold_partial_r1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(held_cnt) < SLOTS);

endmodule

bind tlp_trace_fill tlp_trace_fill_chk #(
  .SLOTS(SLOTS), .DEPTH(BUF_DEPTH), .OUT_W(OUT_W), .BCW(BCW), .HC_W(HC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_hit(fetch_hit), .fetch_miss(fetch_miss),
  .fetch_stall(fetch_stall), .out_valid(out_valid), .buf_cnt(buf_cnt),
  .held_cnt(held_cnt), .wa_en(wa_en), .wb_en(wb_en), .in_flush(in_flush)
);

// File: tb/tlp_trace_fill_test.sv
`timescale 1ns/1ps
module tlp_trace_fill_test;
  localparam int LINES = 4;
  localparam int DEPTH = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  in_cnt;
  logic [63:0] in_uop, in_addr;
  logic [3:0]  in_taken;
  logic        in_flush, fetch_req, out_ready;
  logic [15:0] fetch_addr;
  logic        fetch_hit, fetch_miss, fetch_stall;
  logic [2:0]  out_valid, out_taken;
  logic [47:0] out_uop;

  always #4 clk = ~clk;

  tlp_trace_fill uut (
    .clk(clk), .rst_n(rst_n), .in_cnt(in_cnt), .in_uop(in_uop), .in_taken(in_taken),
    .in_addr(in_addr), .in_flush(in_flush), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .out_ready(out_ready), .fetch_hit(fetch_hit), .fetch_miss(fetch_miss),
    .fetch_stall(fetch_stall), .out_valid(out_valid), .out_uop(out_uop), .out_taken(out_taken)
  );

  typedef struct { int tag; int n; int u[6]; bit t[6]; } line_t;

  int    checks = 0, fails = 0, cyc = 0, seq = 0;
  bit    done = 0;
  line_t st[$];
  int    pk_u[$], pk_a[$];
  bit    pk_t[$];
  int    bu[$];
  bit    bt[$];
  int    lcg = 12345;

  function automatic bit tk_of(int v);
    return (v % 3) == 2;
  endfunction

  function automatic int nxt_rand();
    lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
    return lcg >>> 8;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic cut_line(int cnt);
    line_t ln;
    ln.tag = pk_a[0];
    ln.n   = cnt;
    for (int s = 0; s < 6; s++) begin
      if (s < cnt) begin
        ln.u[s] = pk_u.pop_front();
        ln.t[s] = pk_t.pop_front();
        void'(pk_a.pop_front());
      end else begin
        ln.u[s] = 0;
        ln.t[s] = 0;
      end
    end
    st.push_back(ln);
    if (st.size() > LINES) void'(st.pop_front());
  endtask

  // One core cycle: drive, compare against the model, advance the model.
  task automatic step(int n, bit fl, bit freq, int faddr, bit rdy);
    int  eff, hit_i, k;
    bit  go, room, exp_hit;
    in_cnt = 3'(n); in_flush = fl; fetch_req = freq; fetch_addr = 16'(faddr); out_ready = rdy;
    for (int i = 0; i < 4; i++) begin
      in_uop[i*16 +: 16]  = 16'(seq + i);
      in_addr[i*16 +: 16] = 16'(16'h4000 + seq + i);
      in_taken[i]         = tk_of(seq + i);
    end
    eff = (n > 4) ? 4 : n;
    #1;
    go    = freq && (cyc % 2 == 0);
    hit_i = -1;
    foreach (st[e]) if (st[e].tag == faddr) hit_i = e;
    room    = (DEPTH - bu.size()) >= 6;
    exp_hit = go && hit_i >= 0 && room;
    chk("R6", "fetch_hit", int'(fetch_hit), int'(exp_hit));
    chk("R5", "fetch_miss", int'(fetch_miss), int'(go && hit_i < 0));
    chk("R8", "fetch_stall", int'(fetch_stall), int'(go && hit_i >= 0 && !room));
    k = rdy ? ((bu.size() < 3) ? bu.size() : 3) : 0;
    for (int o = 0; o < 3; o++) begin
      chk("R7", "out_valid", int'(out_valid[o]), int'(o < k));
      if (o < k) begin
        chk("R1", "out_uop", int'(out_uop[o*16 +: 16]), bu[o] & 16'hFFFF);
        chk("R3", "out_taken", int'(out_taken[o]), int'(bt[o]));
      end
    end
    @(posedge clk);
    repeat (k) begin void'(bu.pop_front()); void'(bt.pop_front()); end
    if (exp_hit) begin
      for (int s = 0; s < st[hit_i].n; s++) begin
        bu.push_back(st[hit_i].u[s]);
        bt.push_back(st[hit_i].t[s]);
      end
    end
    for (int i = 0; i < eff; i++) begin
      pk_u.push_back(seq + i); pk_t.push_back(tk_of(seq + i)); pk_a.push_back(16'h4000 + seq + i);
    end
    seq += eff;
    while (pk_u.size() >= 6) cut_line(6);
    if (fl && pk_u.size() > 0) cut_line(pk_u.size());
    cyc++;
    @(negedge clk);
  endtask

  task automatic to_even();
    if (cyc % 2 != 0) step(0, 0, 0, 0, 1);
  endtask

  task automatic drain(int cycles);
    for (int i = 0; i < cycles; i++) step(0, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
    end
  end

  initial begin
    int t1, t2, t3;
    rst_n = 0; in_cnt = 0; in_uop = '0; in_addr = '0; in_taken = '0;
    in_flush = 0; fetch_req = 0; fetch_addr = '0; out_ready = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: nothing asserted during reset
    chk("R10", "out_valid in reset", int'(out_valid), 0);
    chk("R10", "fetch_hit in reset", int'(fetch_hit), 0);
    rst_n = 1;
    // R10: empty store misses on the first window
    step(0, 0, 1, 16'h4000, 1);
    step(0, 0, 0, 0, 1);

    // R1 R2 R3: twelve micro-ops in three pushes give two full lines
    t1 = 16'h4000 + seq;
    step(4, 0, 0, 0, 1); step(4, 0, 0, 0, 1); step(4, 0, 0, 0, 1);
    to_even();
    // R6: request held over an even and an odd cycle is served once
    step(0, 0, 1, t1, 1);
    step(0, 0, 1, t1, 1);
    drain(3);
    step(0, 0, 1, t1 + 6, 1);
    drain(3);

    // R2: an oversized count is taken as four
    t2 = 16'h4000 + seq;
    step(6, 0, 0, 0, 1); step(2, 0, 0, 0, 1);
    to_even(); step(0, 0, 1, t2, 1); drain(3);

    // R4: flushed partial line of three
    t2 = 16'h4000 + seq;
    step(3, 1, 0, 0, 1);
    to_even(); step(0, 0, 1, t2, 1); drain(2);

    // R4: flush with spill writes a full line and a partial one together
    t2 = 16'h4000 + seq;
    step(4, 0, 0, 0, 1); step(1, 0, 0, 0, 1);
    to_even();
    step(3, 1, 1, t2, 1);               // R11: same-cycle write is not visible
    step(0, 0, 0, 0, 1);
    step(0, 0, 1, t2, 1); drain(3);
    step(0, 0, 1, t2 + 6, 1); drain(2);

    // R11: completing push and lookup of the same tag in one cycle
    t3 = 16'h4000 + seq;
    step(4, 0, 0, 0, 1);
    to_even();
    step(2, 0, 1, t3, 1);
    step(0, 0, 0, 0, 1);
    step(0, 0, 1, t3, 1); drain(3);

    // R9: five more lines evict the oldest; t1 must now miss
    for (int i = 0; i < 7; i++) step(4, 0, 0, 0, 1);
    step(2, 1, 0, 0, 1);
    to_even(); step(0, 0, 1, t1, 1);
    step(0, 0, 0, 0, 1);

    // R8: consumer held off until a hit stalls, then retried while draining
    to_even();
    for (int i = 0; i < 4; i++) step(0, 0, 1, st[LINES-2].tag, 0);
    for (int i = 0; i < 8; i++) step(0, 0, 1, st[LINES-2].tag, 1);
    drain(6);

    // Mixed pseudo-random traffic against the model
    for (int i = 0; i < 600; i++) begin
      int r1, r2, r3, fa;
      r1 = nxt_rand(); r2 = nxt_rand(); r3 = nxt_rand();
      fa = 16'hF000 + (r3 % 16);
      if (st.size() > 0 && (r3 % 4) != 0) fa = st[(r3 >> 4) % st.size()].tag;
      step(r1 % 6, (r2 % 8) == 0, (r1 % 2) == 0 || (r2 % 3) == 0, fa, (r2 % 4) != 0);
    end
    drain(8);

    done = 1;
    report();
  end
endmodule